// File: doc/BRIEF.md
# Colour-Bar Source for 8-bit 4:2:2 Digital Video

The block produces a complete 625-line, 50 Hz, 8-bit 4:2:2 component video byte stream at a 27 MHz byte rate. The picture is eight vertical bars at 75% amplitude. The block derives all of the framing itself. A sample counter and a line counter set the timing. Four-byte timing-reference codes, with field, vertical and horizontal flags and protection bits, mark the start and end of active video. The blanking fill and the bar values come from a fixed table.

An output multiplexer picks one of two sources: the local bars, or the incoming byte stream delayed by one register stage. The select input is sampled only at the first byte of each line, so a switch always lands on a line boundary. The output therefore never carries a partial timing code or a shortened line. The F, V and H flags always follow the local raster and go out beside the byte stream as debug outputs.

Every line length, blanking width and line boundary is a parameter. The defaults give the standard 1728-byte, 625-line raster.

Top module: `bt656_bargen`

## Requirements
- R1: While `rst_n` is low, `vout` is 10h and the flags read F=0, V=1, H=1. The raster restarts at the first byte of line 1.
- R2: Each line starts with an end-of-video code FFh, 00h, 00h, status word, and has H=1 in its status word. Directly after the horizontal blanking comes a start-of-video code with the same first three bytes and H=0.
- R3: The status word is {1, F, V, H, V^H, F^H, F^V, F^V^H}, from bit 7 down to bit 0. F is bit 6, V is bit 5, H is bit 4, and bits 3..0 are protection bits.
- R4: A line is 8 + HBLANK + ACTIVE bytes, laid out as end code, HBLANK fill bytes, start code, then ACTIVE picture bytes. The defaults (280 and 1440) give 1728 bytes, and the frame wraps after LINES lines (default 625).
- R5: Blanking fill alternates 80h, 10h, starting with 80h at the first byte after a timing code. It fills the horizontal blanking and the whole picture area of vertical-blanking lines, and never contains FFh or 00h.
- R6: On picture lines, picture byte k (counted from 0 after the start code) is Cb when k mod 4 = 0, Y when it is 1 or 3, and Cr when it is 2. The bar number is k / (ACTIVE/8). Bars 0..7 have the (Y, Cb, Cr) values white (180,128,128), yellow (162,44,142), cyan (131,156,44), green (112,72,58), magenta (84,184,198), red (65,100,212), blue (35,212,114), black (16,128,128).
- R7: V=1 on lines 1..22, 311..335 and 624..625, and V=0 on all other lines. These bounds are parameters.
- R8: F=0 on lines 1..312 and F=1 on lines 313..625. F changes only at the first byte of a line.
- R9: The debug flags are registered together with `vout`. F and V give the current line's values. H is 1 from the first end-code byte up to the last horizontal blanking byte, and 0 from the start code to the end of the line.
- R10: When the passthrough source is in effect, `vout` equals the `vin` value sampled at the previous clock edge. When the local source is in effect, `vout` is the generated byte for the previous raster position.
- R11: `sel_pass` (1 = passthrough) is sampled only at the edge that emits the first end-code byte of a line. A change or pulse at any other time has no effect on `vout` until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin | input | 8 | Incoming byte stream for passthrough |
| sel_pass | input | 1 | 1 selects passthrough, 0 selects local bars |
| vout | output | 8 | Output byte stream |
| f_dbg | output | 1 | Field flag of the local raster |
| v_dbg | output | 1 | Vertical blanking flag of the local raster |
| h_dbg | output | 1 | Horizontal blanking flag of the local raster |

## Verification
A full default frame is over a million bytes, so the bench builds the block with a shrunken raster: 8 blanking bytes, 64 picture bytes and 25 lines. The vertical boundaries are scaled to match, so every vertical region and the field change show up several times within a few thousand cycles. The hardest case is a select change that arrives in the middle of a line. The bench watches its own model's raster position, raises the select mid-line, and holds it pending across the rest of the line. It also pulses the select on and off inside a single line, which must leave the bars untouched. A behavioural model compares every output byte and flag on every clock.

// File: rtl/bt656_pkg.sv
package bt656_pkg;

   localparam logic [7:0] FILL_C = 8'h80;
   localparam logic [7:0] FILL_Y = 8'h10;

   // status word: fixed 1, F, V, H, then four protection bits
   function automatic logic [7:0] trs_status(input logic f, input logic v, input logic h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

   // byte n (0..3) of a timing reference code
   function automatic logic [7:0] trs_byte(input logic [1:0] n, input logic f,
                                           input logic v, input logic h);
      case (n)
         2'd0:    return 8'hFF;
         2'd3:    return trs_status(f, v, h);
         default: return 8'h00;
      endcase
   endfunction

   // 75% bar levels packed as {Y, Cb, Cr}
   function automatic logic [23:0] bar_level(input logic [2:0] idx);
      case (idx)
         3'd0:    return {8'd180, 8'd128, 8'd128};
         3'd1:    return {8'd162, 8'd44,  8'd142};
         3'd2:    return {8'd131, 8'd156, 8'd44};
         3'd3:    return {8'd112, 8'd72,  8'd58};
         3'd4:    return {8'd84,  8'd184, 8'd198};
         3'd5:    return {8'd65,  8'd100, 8'd212};
         3'd6:    return {8'd35,  8'd212, 8'd114};
         default: return {8'd16,  8'd128, 8'd128};
      endcase
   endfunction

endpackage

// File: rtl/bt_raster.sv
module bt_raster #(
   parameter int HBLANK    = 280,
   parameter int ACTIVE    = 1440,
   parameter int LINES     = 625,
   parameter int VB1_END   = 22,
   parameter int VB2_START = 311,
   parameter int VB2_END   = 335,
   parameter int VB3_START = 624,
   parameter int F2_START  = 313,
   localparam int LINE_BYTES = 8 + HBLANK + ACTIVE,
   localparam int CW = $clog2(LINE_BYTES),
   localparam int LW = $clog2(LINES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [CW-1:0] col,
   output logic [LW-1:0] line,
   output logic          f_o,
   output logic          v_o,
   output logic          h_o
);

   localparam logic [CW-1:0] COL_LAST = CW'(LINE_BYTES - 1);
   localparam logic [CW-1:0] SAV_AT   = CW'(4 + HBLANK);
   localparam logic [LW-1:0] LN_LAST  = LW'(LINES);
   localparam logic [LW-1:0] LN_V1E   = LW'(VB1_END);
   localparam logic [LW-1:0] LN_V2S   = LW'(VB2_START);
   localparam logic [LW-1:0] LN_V2E   = LW'(VB2_END);
   localparam logic [LW-1:0] LN_V3S   = LW'(VB3_START);
   localparam logic [LW-1:0] LN_F2    = LW'(F2_START);

   generate
      if (ACTIVE % 32 != 0 || ACTIVE < 32) begin : g_bad_active
         $error("ACTIVE must be a positive multiple of 32");
      end
      if (HBLANK % 2 != 0 || HBLANK < 2) begin : g_bad_hblank
         $error("HBLANK must be even and at least 2");
      end
      if (!(VB1_END >= 1 && VB1_END < VB2_START && VB2_START <= F2_START &&
            F2_START <= VB2_END && VB2_END < VB3_START && VB3_START <= LINES)) begin : g_bad_lines
         $error("vertical boundaries out of order");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col  <= '0;
         line <= LW'(1);
      end else if (col == COL_LAST) begin
         col  <= '0;
         line <= (line == LN_LAST) ? LW'(1) : line + 1'b1;
      end else begin
         col <= col + 1'b1;
      end
   end

   always_comb begin
      v_o = (line <= LN_V1E) || (line >= LN_V2S && line <= LN_V2E) || (line >= LN_V3S);
      f_o = (line >= LN_F2);
      h_o = (col < SAV_AT);
   end

   // R4
   line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col != COL_LAST) |=> $stable(line));

   // R7
   line_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line >= LW'(1)) && (line <= LN_LAST));

endmodule

// File: rtl/bt_pattern.sv
module bt_pattern
   import bt656_pkg::*;
#(
   parameter int HBLANK = 280,
   parameter int ACTIVE = 1440,
   localparam int LINE_BYTES = 8 + HBLANK + ACTIVE,
   localparam int CW = $clog2(LINE_BYTES)
) (
   input  logic [CW-1:0] col,
   input  logic          f,
   input  logic          v,
   output logic [7:0]    byte_o
);

   localparam logic [CW-1:0] SAV_AT = CW'(4 + HBLANK);
   localparam logic [CW-1:0] ACT_AT = CW'(8 + HBLANK);
   localparam logic [CW-1:0] BAR_W  = CW'(ACTIVE / 8);

   logic [CW-1:0] rel;
   logic [23:0]   ycc;

   always_comb begin
      rel    = '0;
      ycc    = '0;
      byte_o = FILL_Y;
      if (col < SAV_AT) begin
         if (col < CW'(4)) byte_o = trs_byte(col[1:0], f, v, 1'b1);
         else              byte_o = col[0] ? FILL_Y : FILL_C;
      end else if (col < ACT_AT) begin
         rel    = col - SAV_AT;
         byte_o = trs_byte(rel[1:0], f, v, 1'b0);
      end else begin
         rel = col - ACT_AT;
         if (v) begin
            byte_o = rel[0] ? FILL_Y : FILL_C;
         end else begin
            ycc = bar_level(3'(rel / BAR_W));
            if (rel[0])      byte_o = ycc[23:16];
            else if (rel[1]) byte_o = ycc[7:0];
            else             byte_o = ycc[15:8];
         end
      end
   end

endmodule

// File: rtl/bt_outsel.sv
module bt_outsel (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       at_line_start,
   input  logic       sel_pass,
   input  logic [7:0] vin,
   input  logic [7:0] gen,
   input  logic       f_in,
   input  logic       v_in,
   input  logic       h_in,
   output logic [7:0] vout,
   output logic       f_o,
   output logic       v_o,
   output logic       h_o,
   output logic       src_pass
);

   logic sel_eff;

   always_comb sel_eff = at_line_start ? sel_pass : src_pass;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vout     <= 8'h10;
         f_o      <= 1'b0;
         v_o      <= 1'b1;
         h_o      <= 1'b1;
         src_pass <= 1'b0;
      end else begin
         vout     <= sel_eff ? vin : gen;
         f_o      <= f_in;
         v_o      <= v_in;
         h_o      <= h_in;
         src_pass <= sel_eff;
      end
   end

endmodule

// File: rtl/bt656_bargen.sv
module bt656_bargen #(
   parameter int HBLANK    = 280,
   parameter int ACTIVE    = 1440,
   parameter int LINES     = 625,
   parameter int VB1_END   = 22,
   parameter int VB2_START = 311,
   parameter int VB2_END   = 335,
   parameter int VB3_START = 624,
   parameter int F2_START  = 313
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] vin,
   input  logic       sel_pass,
   output logic [7:0] vout,
   output logic       f_dbg,
   output logic       v_dbg,
   output logic       h_dbg
);

   localparam int LINE_BYTES = 8 + HBLANK + ACTIVE;
   localparam int CW = $clog2(LINE_BYTES);
   localparam int LW = $clog2(LINES + 1);

   logic [CW-1:0] col;
   logic [LW-1:0] line;
   logic          f_r, v_r, h_r;
   logic [7:0]    gen;
   logic          src_pass;

   bt_raster #(
      .HBLANK(HBLANK), .ACTIVE(ACTIVE), .LINES(LINES),
      .VB1_END(VB1_END), .VB2_START(VB2_START), .VB2_END(VB2_END),
      .VB3_START(VB3_START), .F2_START(F2_START)
   ) u_raster (
      .clk(clk), .rst_n(rst_n), .col(col), .line(line),
      .f_o(f_r), .v_o(v_r), .h_o(h_r)
   );

   bt_pattern #(.HBLANK(HBLANK), .ACTIVE(ACTIVE)) u_pattern (
      .col(col), .f(f_r), .v(v_r), .byte_o(gen)
   );

   bt_outsel u_outsel (
      .clk(clk), .rst_n(rst_n), .at_line_start(col == '0),
      .sel_pass(sel_pass), .vin(vin), .gen(gen),
      .f_in(f_r), .v_in(v_r), .h_in(h_r),
      .vout(vout), .f_o(f_dbg), .v_o(v_dbg), .h_o(h_dbg),
      .src_pass(src_pass)
   );

   // R9
   h_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(h_dbg) && !src_pass) |-> (vout == 8'hFF));

   // R2
   code_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vout == 8'hFF && !src_pass) |=> (vout == 8'h00));

   // R8
   field_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(h_dbg) |-> $stable(f_dbg));

endmodule

// File: tb/sim_bt656_bargen.sv
module sim_bt656_bargen;

   localparam int CLK_PERIOD = 38;
   localparam int HB = 8;
   localparam int ACT = 64;
   localparam int LN = 25;
   localparam int V1E = 2, V2S = 11, V2E = 14, V3S = 24, F2S = 13;
   localparam int LB = 8 + HB + ACT;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] vin = 8'h00;
   logic       sel_pass = 1'b0;
   logic [7:0] vout;
   logic       f_dbg, v_dbg, h_dbg;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   bit live = 1'b0;
   int cyc = 0;

   logic       smp_sel = 1'b0;
   logic [7:0] smp_vin = 8'h00;
   int  mcol = 0;
   int  mline = 1;
   bit  msel = 1'b0;

   bt656_bargen #(
      .HBLANK(HB), .ACTIVE(ACT), .LINES(LN), .VB1_END(V1E), .VB2_START(V2S),
      .VB2_END(V2E), .VB3_START(V3S), .F2_START(F2S)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .vin(vin), .sel_pass(sel_pass),
      .vout(vout), .f_dbg(f_dbg), .v_dbg(v_dbg), .h_dbg(h_dbg)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic bit m_v(int l);
      return (l <= V1E) || (l >= V2S && l <= V2E) || (l >= V3S);
   endfunction

   function automatic bit m_f(int l);
      return l >= F2S;
   endfunction

   function automatic logic [7:0] m_status(bit f, bit v, bit h);
      int s;
      s = 128 + 64*f + 32*v + 16*h + 8*(v^h) + 4*(f^h) + 2*(f^v) + (f^v^h);
      return 8'(s);
   endfunction

   function automatic logic [7:0] m_bar(int bar, int ph);
      int y[8]  = '{180, 162, 131, 112, 84, 65, 35, 16};
      int cb[8] = '{128, 44, 156, 72, 184, 100, 212, 128};
      int cr[8] = '{128, 142, 44, 58, 198, 212, 114, 128};
      if (ph == 0) return 8'(cb[bar]);
      if (ph == 2) return 8'(cr[bar]);
      return 8'(y[bar]);
   endfunction

   // expected local byte and the requirement it belongs to
   function automatic logic [7:0] m_gen(int c, int l, output string tag);
      int k;
      bit f, v;
      f = m_f(l);
      v = m_v(l);
      if (c < 4 || (c >= 4 + HB && c < 8 + HB)) begin
         k = (c < 4) ? c : c - 4 - HB;
         if (k == 3) begin tag = "R3"; return m_status(f, v, c < 4); end
         tag = (c == 0) ? "R4" : "R2";
         return (k == 0) ? 8'hFF : 8'h00;
      end
      if (c < 4 + HB) begin
         tag = "R5";
         return ((c - 4) % 2 == 0) ? 8'h80 : 8'h10;
      end
      k = c - 8 - HB;
      if (v) begin
         tag = "R5";
         return (k % 2 == 0) ? 8'h80 : 8'h10;
      end
      tag = "R6";
      return m_bar(k / (ACT / 8), k % 4);
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at line %0d col %0d: actual=%02h expected=%02h",
                  tag, mline, mcol, act, exp);
      end
   endtask

   always @(posedge clk) begin
      smp_sel <= sel_pass;
      smp_vin <= vin;
      live    <= rst_n;
      cyc     <= cyc + 1;
   end

   always @(posedge clk) begin
      #2 vin = 8'($urandom);
   end

   // cycle-by-cycle reference comparison
   always @(negedge clk) begin
      if (live && rst_n && !done) begin
         string tag;
         logic [7:0] g;
         bit eff;
         g   = m_gen(mcol, mline, tag);
         eff = (mcol == 0) ? smp_sel : msel;
         if (mcol != 0 && smp_sel != msel) tag = "R11";
         if (eff) chk((mcol != 0 && smp_sel != msel) ? "R11" : "R10", vout, smp_vin);
         else     chk(tag, vout, g);
         msel = eff;
         chk("R8", {7'd0, f_dbg}, {7'd0, m_f(mline)});
         chk("R7", {7'd0, v_dbg}, {7'd0, m_v(mline)});
         chk("R9", {7'd0, h_dbg}, {7'd0, (mcol < 4 + HB)});
         mcol++;
         if (mcol == LB) begin
            mcol = 0;
            mline = (mline == LN) ? 1 : mline + 1;
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wait_col(int c);
      while (mcol != c) @(posedge clk);
      #2;
   endtask

   initial begin
      step(3);
      @(negedge clk);
      // R1 reset state
      chk("R1", vout, 8'h10);
      chk("R1", {5'd0, f_dbg, v_dbg, h_dbg}, 8'h03);
      @(posedge clk);
      #2 rst_n = 1'b1;
      step(2 * LB * LN + 37);
      // R10: switch to passthrough mid-line
      sel_pass = 1'b1;
      step(LB * LN + 211);
      // back to bars mid-line
      sel_pass = 1'b0;
      step(3 * LB + 13);
      // R11: a pulse inside one line has no effect
      wait_col(10);
      sel_pass = 1'b1;
      step(20);
      sel_pass = 1'b0;
      step(2 * LB);
      // R11: pending request held across the rest of a line
      wait_col(30);
      sel_pass = 1'b1;
      step(2 * LB + 5);
      wait_col(40);
      sel_pass = 1'b0;
      step(LB * LN + 50);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule